// File: doc/BRIEF.md
# Two-level SMI status collector

This block gathers system-management interrupt events from several sources and turns them into one SMI request. The sources are an idle-timer expiry, a disk access trap, a peripheral-port access trap, a thermal override, a power-up request and a summary of GPIO transitions. Each enabled source pulse is held in a second-level status byte. The OR of the held bits is the top-level summary, and that summary drives `smi_o`.

Software reads the status byte at two addresses. A read at the mirror address has no side effect. A read at the clearing address returns the same byte and, in the same access, clears every held bit except the GPIO bit. The GPIO bit has no storage of its own. It follows a third-level register of per-GPIO event flags, and software clears those flags through a separate write-one-to-clear address. A small register bus gives access to the enables, the GPIO selection and the GPIO input configuration.

Register map on the 3-bit address: 0 mirror (read only), 1 clearing read, 2 control, 3 GPIO select, 4 GPIO input configuration, 5 third-level GPIO flags (read, write 1 to clear).

Top module: `smi_status_agg`

## Requirements
- R1: After reset, the status byte reads 00h at both status addresses, the control register reads 80h, and `smi_o` is 0.
- R2: An enabled source pulse sets its status bit at the next clock edge, and the byte reads it from then on. The bit positions are: bit 0 idle timer, bit 1 disk trap, bit 2 port trap, bit 3 power-up request, bit 6 thermal, bit 7 GPIO summary.
- R3: A pulse from a disabled source leaves its status bit at 0.
- R4: Control bits 0, 1, 2 and 6 enable the idle-timer, disk-trap, port-trap and thermal sources, each active when 1. Control bit 7 is a shared active-low enable for the power-up request and the GPIO summary, which are enabled when it is 0.
- R5: A read at the mirror address returns the status byte and leaves every bit at every level unchanged.
- R6: A read at the clearing address returns the status byte. It clears bits 0 to 3 and bit 6 at the clock edge that ends the access, and the summary drops with them.
- R7: With control bit 7 at 0, status bit 7 reads 1 whenever any third-level GPIO flag is set. A clearing read does not change it. It falls only after the flags are cleared by writing 1s to address 5.
- R8: Third-level GPIO flag i is set by a transition pulse on GPIO i only when select bit i (address 3) and input-configuration bit i (address 4) are both 1.
- R9: Status bits 5 and 4 always read 0.
- R10: A source pulse that arrives in the same cycle as a clearing read leaves its bit set after that read.
- R11: Writes to address 0 or 1 change no status bit.
- R12: `smi_o` is 1 exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| evt_idle | input | 1 | Idle-timer expiry pulse |
| evt_dtrap | input | 1 | Disk access trap pulse |
| evt_ptrap | input | 1 | Peripheral-port access trap pulse |
| evt_therm | input | 1 | Thermal override pulse |
| evt_pwr | input | 1 | Power-up request pulse |
| gpio_edge | input | GPIO_N | Per-GPIO transition pulses |
| smi_o | output | 1 | SMI request, high while the summary is set |

## Verification
The bench sweeps every source with its enable on and with it off. For each case it reads the mirror twice and then issues a clearing read. A mirror that clears would lose the bit on the second read. A clearing read that misses the clear would leave `smi_o` high. The GPIO sweep covers every select and input-configuration pair for every line under both settings of the shared active-low enable. It catches an inverted enable, a gate on a single qualifier, and a GPIO bit that the clearing read wipes. Further cases place a pulse in the same cycle as a clearing read, where a design that lets the clear win would lose the event, and write to both status addresses, where a design that treats them as writable would corrupt the byte.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MIRROR = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_GSEL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_GDIR   = 3'd4;
  localparam logic [ADDR_W-1:0] A_GSTAT  = 3'd5;

  localparam int B_IDLE  = 0;
  localparam int B_DTRAP = 1;
  localparam int B_PTRAP = 2;
  localparam int B_PWR   = 3;
  localparam int B_THERM = 6;
  localparam int B_GPIO  = 7;
  localparam int C_WAKE_N = 7;

  localparam logic [DATA_W-1:0] CTRL_RST   = 8'h80;
  localparam logic [DATA_W-1:0] LATCH_MASK = 8'b0100_1111;

  // held bits after one clock: clear first, then new events on top
  function automatic logic [DATA_W-1:0] next_status(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] evt,
    input logic [DATA_W-1:0] en,
    input logic              clr
  );
    logic [DATA_W-1:0] kept;
    kept = clr ? '0 : cur;
    return (kept | (evt & en)) & LATCH_MASK;
  endfunction

  // third-level flag update: write-one-to-clear, events win
  function automatic logic [DATA_W-1:0] next_flags(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] edge_v,
    input logic [DATA_W-1:0] qual,
    input logic [DATA_W-1:0] clr_mask
  );
    return (cur & ~clr_mask) | (edge_v & qual);
  endfunction
endpackage

// File: rtl/smi_ctrl_regs.sv
module smi_ctrl_regs
  import smi_pkg::*;
#(
  parameter int GPIO_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [GPIO_N-1:0] gsel_q,
  output logic [GPIO_N-1:0] gdir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      gsel_q <= '0;
      gdir_q <= '0;
    end else if (wr_stb) begin
      if (addr == A_CTRL) ctrl_q <= wdata;
      if (addr == A_GSEL) gsel_q <= wdata[GPIO_N-1:0];
      if (addr == A_GDIR) gdir_q <= wdata[GPIO_N-1:0];
    end
  end
endmodule

// File: rtl/smi_gpio_lvl3.sv
module smi_gpio_lvl3
  import smi_pkg::*;
#(
  parameter int GPIO_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_N-1:0] gpio_edge,
  input  logic [GPIO_N-1:0] gsel,
  input  logic [GPIO_N-1:0] gdir,
  input  logic              clr_stb,
  input  logic [GPIO_N-1:0] clr_mask,
  output logic [GPIO_N-1:0] flags_q,
  output logic              gpio_any
);
  logic [DATA_W-1:0] cur_w, edge_w, qual_w, clr_w, nxt_w;

  always_comb begin
    cur_w  = '0;
    edge_w = '0;
    qual_w = '0;
    clr_w  = '0;
    cur_w[GPIO_N-1:0]  = flags_q;
    edge_w[GPIO_N-1:0] = gpio_edge;
    qual_w[GPIO_N-1:0] = gsel & gdir;
    if (clr_stb) clr_w[GPIO_N-1:0] = clr_mask;
    nxt_w = next_flags(cur_w, edge_w, qual_w, clr_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= nxt_w[GPIO_N-1:0];
  end

  assign gpio_any = |flags_q;
endmodule

// File: rtl/smi_status_core.sv
module smi_status_core
  import smi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_vec,
  input  logic [DATA_W-1:0] en_vec,
  input  logic              clr_rd,
  input  logic              gpio_flag,
  output logic [DATA_W-1:0] status_w,
  output logic              summary
);
  logic [DATA_W-1:0] nxt_w;
  assign nxt_w = next_status(status_w, evt_vec, en_vec, clr_rd);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (LATCH_MASK[b]) begin : g_held
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt_w[b];
      end
      assign status_w[b] = q;
    end else if (b == B_GPIO) begin : g_gpio
      assign status_w[b] = gpio_flag;
    end else begin : g_rsvd
      assign status_w[b] = 1'b0;
    end
  end

  assign summary = |status_w;
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_pkg::*;
#(
  parameter int GPIO_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_idle,
  input  logic              evt_dtrap,
  input  logic              evt_ptrap,
  input  logic              evt_therm,
  input  logic              evt_pwr,
  input  logic [GPIO_N-1:0] gpio_edge,
  output logic              smi_o
);
  logic              rd_stb, wr_stb, clr_rd, gstat_clr;
  logic [DATA_W-1:0] ctrl_q;
  logic [GPIO_N-1:0] gsel_q, gdir_q, flags_q;
  logic              gpio_any, gpio_path_en, gpio_flag;
  logic [DATA_W-1:0] evt_vec, en_vec, status_w;
  logic              evt_hit, summary;

  assign rd_stb    = bus_req & ~bus_wr;
  assign wr_stb    = bus_req & bus_wr;
  assign clr_rd    = rd_stb & (bus_addr == A_CLEAR);
  assign gstat_clr = wr_stb & (bus_addr == A_GSTAT);

  smi_ctrl_regs #(.GPIO_N(GPIO_N)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(bus_addr),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .gsel_q(gsel_q), .gdir_q(gdir_q)
  );

  smi_gpio_lvl3 #(.GPIO_N(GPIO_N)) i_lvl3 (
    .clk(clk), .rst_n(rst_n), .gpio_edge(gpio_edge), .gsel(gsel_q),
    .gdir(gdir_q), .clr_stb(gstat_clr), .clr_mask(bus_wdata[GPIO_N-1:0]),
    .flags_q(flags_q), .gpio_any(gpio_any)
  );

  assign gpio_path_en = ~ctrl_q[C_WAKE_N];
  assign gpio_flag    = gpio_any & gpio_path_en;

  always_comb begin
    evt_vec = '0;
    en_vec  = '0;
    evt_vec[B_IDLE]  = evt_idle;
    evt_vec[B_DTRAP] = evt_dtrap;
    evt_vec[B_PTRAP] = evt_ptrap;
    evt_vec[B_PWR]   = evt_pwr;
    evt_vec[B_THERM] = evt_therm;
    en_vec[B_IDLE]   = ctrl_q[B_IDLE];
    en_vec[B_DTRAP]  = ctrl_q[B_DTRAP];
    en_vec[B_PTRAP]  = ctrl_q[B_PTRAP];
    en_vec[B_THERM]  = ctrl_q[B_THERM];
    en_vec[B_PWR]    = gpio_path_en;
  end

  assign evt_hit = |(evt_vec & en_vec);

  smi_status_core i_core (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .en_vec(en_vec),
    .clr_rd(clr_rd), .gpio_flag(gpio_flag), .status_w(status_w),
    .summary(summary)
  );

  assign smi_o = summary;

  always_comb begin
    bus_rdata = '0;
    if (rd_stb) begin
      case (bus_addr)
        A_MIRROR, A_CLEAR: bus_rdata = status_w;
        A_CTRL:            bus_rdata = ctrl_q;
        A_GSEL:            bus_rdata[GPIO_N-1:0] = gsel_q;
        A_GDIR:            bus_rdata[GPIO_N-1:0] = gdir_q;
        A_GSTAT:           bus_rdata[GPIO_N-1:0] = flags_q;
        default:           bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/smi_status_chk.sv
module smi_status_chk
  import smi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] status_w,
  input logic [DATA_W-1:0] en_vec,
  input logic              evt_hit,
  input logic              clr_rd,
  input logic              gpio_flag,
  input logic              evt_therm,
  input logic              smi_o
);
  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (bus_addr == A_MIRROR || bus_addr == A_CLEAR)) |-> (bus_rdata[5:4] == 2'b00));

  // R5
  mirror_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && bus_addr == A_MIRROR && !evt_hit) |=> $stable(status_w[6:0]));

  // R6
  clear_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !evt_hit) |=> ((status_w & LATCH_MASK) == 8'h00));

  // R10
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && evt_hit) |=> ((status_w & LATCH_MASK) != 8'h00));

  // R7
  gpio_drives_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_flag |-> smi_o);

  // R3
  therm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_therm && !en_vec[B_THERM] && !status_w[B_THERM] && !clr_rd) |=> !status_w[B_THERM]);

  // R12
  smi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_o |-> (status_w == 8'h00));
endmodule

bind smi_status_agg smi_status_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .status_w(status_w), .en_vec(en_vec),
  .evt_hit(evt_hit), .clr_rd(clr_rd), .gpio_flag(gpio_flag),
  .evt_therm(evt_therm), .smi_o(smi_o)
);

// File: tb/test_smi_status_agg.sv
`timescale 1ns/1ps
module test_smi_status_agg;
  localparam int GN = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          evt_idle = 0, evt_dtrap = 0, evt_ptrap = 0, evt_therm = 0, evt_pwr = 0;
  logic [GN-1:0] gpio_edge = '0;
  logic          smi_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smi_status_agg #(.GPIO_N(GN)) i_smi_status_agg (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_idle(evt_idle), .evt_dtrap(evt_dtrap), .evt_ptrap(evt_ptrap),
    .evt_therm(evt_therm), .evt_pwr(evt_pwr), .gpio_edge(gpio_edge),
    .smi_o(smi_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic set_evt(input int b, input logic v);
    case (b)
      0: evt_idle  = v;
      1: evt_dtrap = v;
      2: evt_ptrap = v;
      3: evt_pwr   = v;
      6: evt_therm = v;
      default: ;
    endcase
  endtask

  task automatic pulse(input int b);
    @(negedge clk);
    set_evt(b, 1'b1);
    @(posedge clk); #1;
    set_evt(b, 1'b0);
  endtask

  // control byte enabling only source b (R4 encoding)
  function automatic logic [7:0] ctrl_for(input int b, input bit en);
    if (b == 3) return en ? 8'h00 : 8'h80;
    return en ? (8'h80 | (8'h01 << b)) : 8'h80;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, exp;
    int srcs[5] = '{0, 1, 2, 3, 6};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(3'd0, d); chk("R1 mirror", d, 8'h00);
    rd(3'd1, d); chk("R1 clear", d, 8'h00);
    rd(3'd2, d); chk("R1 ctrl", d, 8'h80);
    chk("R1 smi", {7'd0, smi_o}, 8'h00);

    // R2 R3 R4 R5 R6 R9 R12 source sweep
    foreach (srcs[k]) begin
      for (int en = 0; en < 2; en++) begin
        int b = srcs[k];
        wr(3'd2, ctrl_for(b, en != 0));
        pulse(b);
        exp = (en != 0) ? (8'h01 << b) : 8'h00;
        chk(en != 0 ? "R2 smi" : "R3 smi", {7'd0, smi_o}, {7'd0, exp != 0});
        rd(3'd0, d); chk(en != 0 ? "R2 mirror" : "R3 mirror", d, exp);
        chk("R9 reserved", d & 8'h30, 8'h00);
        rd(3'd0, d); chk("R5 mirror again", d, exp);
        chk("R12 smi held", {7'd0, smi_o}, {7'd0, exp != 0});
        rd(3'd1, d); chk("R6 clear returns", d, exp);
        chk("R6 smi low", {7'd0, smi_o}, 8'h00);
        rd(3'd0, d); chk("R6 cleared", d, 8'h00);
      end
    end

    // R4 all active-high enables set, power-up disabled by ctrl bit7=1
    wr(3'd2, 8'hC7);
    pulse(3);
    rd(3'd0, d); chk("R4 pwr masked by bit7", d, 8'h00);

    // R8 R7 GPIO sweep
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < GN; i++) begin
        for (int q = 0; q < 4; q++) begin
          logic [7:0] f;
          logic hit;
          hit = (q == 3);
          wr(3'd2, (w != 0) ? 8'h80 : 8'h00);
          wr(3'd3, (q & 1) ? (8'h01 << i) : 8'h00);
          wr(3'd4, (q & 2) ? (8'h01 << i) : 8'h00);
          @(negedge clk); gpio_edge = GN'(1) << i;
          @(posedge clk); #1 gpio_edge = '0;
          rd(3'd5, f); chk("R8 flags", f, hit ? (8'h01 << i) : 8'h00);
          exp = (hit && w == 0) ? 8'h80 : 8'h00;
          rd(3'd0, d); chk("R7 bit7", d, exp);
          rd(3'd1, d); chk("R7 clear read", d, exp);
          rd(3'd0, d); chk("R7 survives clear", d, exp);
          chk("R12 smi gpio", {7'd0, smi_o}, {7'd0, exp != 0});
          wr(3'd5, 8'hFF);
          rd(3'd0, d); chk("R7 lvl3 cleared", d, 8'h00);
        end
      end
    end

    // R10 event coincident with clearing read
    wr(3'd2, 8'h47);
    pulse(0);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = 3'd1; evt_therm = 1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0; evt_therm = 0;
    chk("R10 read value", d, 8'h01);
    rd(3'd0, d); chk("R10 event kept", d, 8'h40);
    rd(3'd1, d);

    // R11 writes to status addresses ignored
    pulse(1);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h00);
    rd(3'd0, d); chk("R11 status kept", d, 8'h02);
    rd(3'd1, d);
    wr(3'd1, 8'hFF);
    rd(3'd0, d); chk("R11 no set", d, 8'h00);
    chk("R12 final smi", {7'd0, smi_o}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule